// File: doc/BRIEF.md
# USART Register Front End with Interrupt Lines

This block is the register-facing half of a serial port. A byte-wide bus reaches a small window of registers through a 3-bit offset. The window holds a data port, a status byte, two control bytes and a 12-bit divisor split across two bytes. Received characters arrive on a valid/ready byte stream and wait in a one-entry holding buffer until software reads the data port. Bytes that software writes to the data port leave the block at once on an output byte stream.

Three level interrupt lines report a received character, a completed transmission and an empty data register. Each line is raised from its status flag, gated by its enable bit. Received characters are masked to the configured width of 5 to 8 bits. The width code is split between the two control bytes. A power-reduction input holds the whole block in reset and isolates it from the bus.

Bit timing, parity, the divisor counter and the synchronous modes are not implemented here. Their control bits are only stored.

Top module: `uart_regfront`

## Requirements
- R1: After reset, status reads 0x20, control byte B (offset 2) reads 0x00, control byte C (offset 3) reads 0x06, both divisor bytes (offsets 4 and 5) read 0x00, the buffer is empty and all three interrupt lines are low.
- R2: `rx_ready` is high only when the buffer is empty, receive-enable (B bit 4) is set and the cycle carries neither a data-port read nor a write to B. An accepted byte is stored, sets status bit 7 and raises `irq_rx_done` if B bit 7 is set.
- R3: With receive-enable set, a data-port (offset 0) read returns the stored byte ANDed with the width mask, or 0 if the buffer is empty. The read empties the buffer, clears status bit 7 and lowers `irq_rx_done`.
- R4: With receive-enable clear, a data-port read returns 0 and has no effect. Status bit 7 and `irq_rx_done` keep their values.
- R5: The width code is C bit 1 (weight 1), C bit 2 (weight 2) and B bit 2 (weight 4). Codes 0, 1, 2 and 3 select masks 0x1F, 0x3F, 0x7F and 0xFF, and code 7 selects 0xFF. Codes 4 to 6 keep the previous mask. The code is evaluated on every write to B or C.
- R6: A data-port write with transmit-enable (B bit 3) clear is ignored and `tx_valid` stays low. With transmit-enable set, the byte appears on `tx_data` with `tx_valid` high in that same cycle, and status bits 6 and 5 are set. If B bit 6 is set, `irq_tx_done` rises and status bit 6 is cleared at once. If B bit 5 is set, `irq_dr_empty` rises.
- R7: A status write changes only the bits in 0x43, and status bit 6 ends up clear. If the written bit 6 is 1, `irq_tx_done` is lowered.
- R8: A write to B changes only the bits in 0xFD, so bit 1 keeps its value. Writing receive-enable as 0 flushes the buffer. Each interrupt line is then set to its enable bit (B bits 7, 6, 5) ANDed with its status flag (bits 7, 6, 5).
- R9: Control byte C and the low divisor byte store all 8 written bits. The high divisor byte keeps only its low 4 bits.
- R10: While `pwr_off` is high, `bus_rdata` is 0, writes have no effect, `tx_valid` and `rx_ready` are low, and one cycle later all state is back at its reset value.
- R11: Offsets 6 and 7 read as 0, and writes to them change nothing.
- R12: A data-port read and an arriving byte in the same cycle resolve as read first. The byte is not taken in that cycle and is accepted on the next cycle in which it is still offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pwr_off | input | 1 | Power-reduction hold, acts as reset and isolates the bus |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, side effects on the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Holding buffer can take the offered byte |
| tx_valid | output | 1 | Outgoing byte present this cycle |
| tx_data | output | 8 | Outgoing byte |
| irq_rx_done | output | 1 | Receive-complete interrupt level |
| irq_tx_done | output | 1 | Transmit-complete interrupt level |
| irq_dr_empty | output | 1 | Data-register-empty interrupt level |

## Verification
Two same-cycle events meet in this block. A software read of the data port can coincide with a byte arriving on the receive stream. A write to control byte B can coincide with an arrival and flush the buffer. The bench drives the arrival and the data-port read in the same cycle, once with the buffer full and once with it empty. It checks that `rx_ready` is low in that cycle, that the read returns the old contents (or 0), that `rx_ready` rises on the next cycle, and that a later read returns the new byte.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 3;

    // register offsets
    localparam logic [OFS_W-1:0] OFS_DATA  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_STAT  = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CTRL  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_FRAME = 3'd3;
    localparam logic [OFS_W-1:0] OFS_DIVL  = 3'd4;
    localparam logic [OFS_W-1:0] OFS_DIVH  = 3'd5;

    // status byte bit positions
    localparam int ST_RXDONE = 7;
    localparam int ST_TXDONE = 6;
    localparam int ST_EMPTY  = 5;

    // control byte B bit positions
    localparam int CB_RXIE = 7;
    localparam int CB_TXIE = 6;
    localparam int CB_EMIE = 5;
    localparam int CB_RXON = 4;
    localparam int CB_TXON = 3;
    localparam int CB_SZ2  = 2;

    // control byte C bit positions
    localparam int CC_SZ1 = 2;
    localparam int CC_SZ0 = 1;

    // reset constants
    localparam logic [BYTE_W-1:0] STAT_RST  = 8'h20;
    localparam logic [BYTE_W-1:0] CTRL_RST  = 8'h00;
    localparam logic [BYTE_W-1:0] FRAME_RST = 8'h06;
    localparam logic [BYTE_W-1:0] MASK_RST  = 8'hFF;

    // writable bit masks
    localparam logic [BYTE_W-1:0] WMASK_STAT = 8'h43;
    localparam logic [BYTE_W-1:0] WMASK_CTRL = 8'hFD;

    typedef struct packed {
        logic data_rd;
        logic data_wr;
        logic stat_wr;
        logic ctrl_wr;
        logic frame_wr;
        logic divl_wr;
        logic divh_wr;
    } reg_hit_t;

    typedef struct packed {
        logic rx;
        logic tx;
        logic empty;
    } irq_t;

    function automatic logic [2:0] size_code(input logic [BYTE_W-1:0] ctrl,
                                             input logic [BYTE_W-1:0] frame);
        return {ctrl[CB_SZ2], frame[CC_SZ1], frame[CC_SZ0]};
    endfunction

    function automatic logic [BYTE_W-1:0] width_mask(input logic [2:0] code,
                                                     input logic [BYTE_W-1:0] prev);
        logic [BYTE_W-1:0] m;
        case (code)
            3'd0:       m = 8'h1F;
            3'd1:       m = 8'h3F;
            3'd2:       m = 8'h7F;
            3'd3, 3'd7: m = 8'hFF;
            default:    m = prev;
        endcase
        return m;
    endfunction

    function automatic logic [BYTE_W-1:0] merge_bits(input logic [BYTE_W-1:0] nv,
                                                     input logic [BYTE_W-1:0] ov,
                                                     input logic [BYTE_W-1:0] wm);
        return (nv & wm) | (ov & ~wm);
    endfunction

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
(
    input  logic             hold,
    input  logic             rd,
    input  logic             wr,
    input  logic [OFS_W-1:0] addr,
    output reg_hit_t         hit
);
    logic rd_ok, wr_ok;

    assign rd_ok = rd && !hold;
    assign wr_ok = wr && !hold;

    always_comb begin
        hit          = '0;
        hit.data_rd  = rd_ok && (addr == OFS_DATA);
        hit.data_wr  = wr_ok && (addr == OFS_DATA);
        hit.stat_wr  = wr_ok && (addr == OFS_STAT);
        hit.ctrl_wr  = wr_ok && (addr == OFS_CTRL);
        hit.frame_wr = wr_ok && (addr == OFS_FRAME);
        hit.divl_wr  = wr_ok && (addr == OFS_DIVL);
        hit.divh_wr  = wr_ok && (addr == OFS_DIVH);
    end
endmodule

// File: rtl/uart_rf_rxbuf.sv
module uart_rf_rxbuf
    import uart_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              rx_on,
    input  logic              take,
    input  logic              block,
    input  logic              flush,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              accept,
    output logic              full,
    output logic [BYTE_W-1:0] held
);
    assign rx_ready = rx_on && !full && !block && !hold;
    assign accept   = rx_valid && rx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else begin
            if (accept) begin
                full <= 1'b1;
                held <= rx_data;
            end else if (take || flush) begin
                full <= 1'b0;
            end
        end
    end

    // R2
    rx_ready_needs_empty_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> !full);

    // R2
    accept_fills_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready) |=> (full && held == $past(rx_data)));

    // R3
    take_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !rx_valid) |=> !full);

    // R12
    read_before_arrival_chk: assert property (@(posedge clk) disable iff (rst)
        (block && !full) |=> !full);
endmodule

// File: rtl/uart_rf_sizemask.sv
module uart_rf_sizemask
    import uart_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              update,
    input  logic [2:0]        code,
    output logic [BYTE_W-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst)
            mask <= MASK_RST;
        else if (update)
            mask <= width_mask(code, mask);
    end

    // R5
    reserved_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (update && code[2] && (code[1:0] != 2'b11)) |=> (mask == $past(mask)));

    // R5
    nine_forced_eight_chk: assert property (@(posedge clk) disable iff (rst)
        (update && code == 3'd7) |=> (mask == 8'hFF));
endmodule

// File: rtl/uart_rf_ctrl.sv
module uart_rf_ctrl
    import uart_rf_pkg::*;
#(
    parameter int DIVH_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_hit_t          hit,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_accept,
    output logic              rx_take,
    output logic              tx_fire,
    output logic              rx_flush,
    output logic [BYTE_W-1:0] stat,
    output logic [BYTE_W-1:0] ctrl,
    output logic [BYTE_W-1:0] frame,
    output logic [BYTE_W-1:0] divl,
    output logic [DIVH_W-1:0] divh,
    output irq_t              irq
);
    localparam logic [BYTE_W-1:0] DIVH_KEEP = BYTE_W'((1 << DIVH_W) - 1);

    logic [BYTE_W-1:0] stat_n, ctrl_n, frame_n, divl_n;
    logic [DIVH_W-1:0] divh_n;
    irq_t              irq_n;

    assign rx_take  = hit.data_rd && ctrl[CB_RXON];
    assign tx_fire  = hit.data_wr && ctrl[CB_TXON];
    assign rx_flush = hit.ctrl_wr && !wdata[CB_RXON];

    always_comb begin
        stat_n  = stat;
        ctrl_n  = ctrl;
        frame_n = frame;
        divl_n  = divl;
        divh_n  = divh;
        irq_n   = irq;

        if (rx_accept) begin
            stat_n[ST_RXDONE] = 1'b1;
            if (ctrl[CB_RXIE])
                irq_n.rx = 1'b1;
        end

        if (rx_take) begin
            stat_n[ST_RXDONE] = 1'b0;
            irq_n.rx          = 1'b0;
        end

        if (tx_fire) begin
            stat_n[ST_TXDONE] = 1'b1;
            stat_n[ST_EMPTY]  = 1'b1;
            if (ctrl[CB_TXIE]) begin
                irq_n.tx          = 1'b1;
                stat_n[ST_TXDONE] = 1'b0;
            end
            if (ctrl[CB_EMIE])
                irq_n.empty = 1'b1;
        end

        if (hit.stat_wr) begin
            stat_n = merge_bits(wdata, stat_n, WMASK_STAT);
            if (wdata[ST_TXDONE]) begin
                stat_n[ST_TXDONE] = 1'b0;
                irq_n.tx          = 1'b0;
            end
        end

        if (hit.ctrl_wr) begin
            ctrl_n      = merge_bits(wdata, ctrl, WMASK_CTRL);
            irq_n.rx    = wdata[CB_RXIE] && stat[ST_RXDONE];
            irq_n.tx    = wdata[CB_TXIE] && stat[ST_TXDONE];
            irq_n.empty = wdata[CB_EMIE] && stat[ST_EMPTY];
        end

        if (hit.frame_wr)
            frame_n = wdata;

        if (hit.divl_wr)
            divl_n = wdata;

        if (hit.divh_wr)
            divh_n = DIVH_W'(wdata & DIVH_KEEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat  <= STAT_RST;
            ctrl  <= CTRL_RST;
            frame <= FRAME_RST;
            divl  <= '0;
            divh  <= '0;
            irq   <= '0;
        end else begin
            stat  <= stat_n;
            ctrl  <= ctrl_n;
            frame <= frame_n;
            divl  <= divl_n;
            divh  <= divh_n;
            irq   <= irq_n;
        end
    end

    // R1
    reset_values_chk: assert property (@(posedge clk)
        rst |=> (stat == STAT_RST && ctrl == CTRL_RST && frame == FRAME_RST &&
                 divl == '0 && divh == '0 && irq == '0));

    // R2
    accept_flags_chk: assert property (@(posedge clk) disable iff (rst)
        rx_accept |=> (stat[ST_RXDONE] && (irq.rx == $past(ctrl[CB_RXIE]))));

    // R6
    tx_irq_fold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_fire && ctrl[CB_TXIE]) |=> (irq.tx && !stat[ST_TXDONE] && stat[ST_EMPTY]));

    // R7
    stat_write_txdone_chk: assert property (@(posedge clk) disable iff (rst)
        hit.stat_wr |=> !stat[ST_TXDONE]);

    // R7
    stat_write_drops_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (hit.stat_wr && wdata[ST_TXDONE]) |=> !irq.tx);

    // R8
    ctrl_bit1_kept_chk: assert property (@(posedge clk) disable iff (rst)
        hit.ctrl_wr |=> (ctrl[1] == $past(ctrl[1])));

    // R8
    ctrl_irq_recompute_chk: assert property (@(posedge clk) disable iff (rst)
        hit.ctrl_wr |=> (irq.empty == (ctrl[CB_EMIE] && stat[ST_EMPTY])));
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
#(
    parameter int DIVH_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_off,
    input  logic [2:0]       bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             irq_rx_done,
    output logic             irq_tx_done,
    output logic             irq_dr_empty
);
    logic              rst_eff;
    reg_hit_t          hit;
    logic              rx_take, tx_fire, rx_flush, rx_accept, buf_full;
    logic [BYTE_W-1:0] held, mask, stat, ctrl, frame, divl;
    logic [DIVH_W-1:0] divh;
    irq_t              irq;
    logic [BYTE_W-1:0] rd_mux;

    assign rst_eff = rst || pwr_off;

    uart_rf_decode u_dec (
        .hold (pwr_off),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .addr (bus_addr),
        .hit  (hit)
    );

    uart_rf_ctrl #(.DIVH_W(DIVH_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst_eff),
        .hit       (hit),
        .wdata     (bus_wdata),
        .rx_accept (rx_accept),
        .rx_take   (rx_take),
        .tx_fire   (tx_fire),
        .rx_flush  (rx_flush),
        .stat      (stat),
        .ctrl      (ctrl),
        .frame     (frame),
        .divl      (divl),
        .divh      (divh),
        .irq       (irq)
    );

    uart_rf_rxbuf u_rxbuf (
        .clk      (clk),
        .rst      (rst_eff),
        .hold     (pwr_off),
        .rx_on    (ctrl[CB_RXON]),
        .take     (rx_take),
        .block    (hit.data_rd || hit.ctrl_wr),
        .flush    (rx_flush),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .accept   (rx_accept),
        .full     (buf_full),
        .held     (held)
    );

    uart_rf_sizemask u_mask (
        .clk    (clk),
        .rst    (rst_eff),
        .update (hit.ctrl_wr || hit.frame_wr),
        .code   (hit.ctrl_wr ? size_code(merge_bits(bus_wdata, ctrl, WMASK_CTRL), frame)
                             : size_code(ctrl, bus_wdata)),
        .mask   (mask)
    );

    always_comb begin
        case (bus_addr)
            OFS_DATA:  rd_mux = (ctrl[CB_RXON] && buf_full) ? (held & mask) : '0;
            OFS_STAT:  rd_mux = stat;
            OFS_CTRL:  rd_mux = ctrl;
            OFS_FRAME: rd_mux = frame;
            OFS_DIVL:  rd_mux = divl;
            OFS_DIVH:  rd_mux = BYTE_W'(divh);
            default:   rd_mux = '0;
        endcase
    end

    assign bus_rdata    = (bus_rd && !pwr_off) ? rd_mux : '0;
    assign tx_valid     = tx_fire;
    assign tx_data      = bus_wdata;
    assign irq_rx_done  = irq.rx;
    assign irq_tx_done  = irq.tx;
    assign irq_dr_empty = irq.empty;

    // R10
    pwr_isolate_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_off |-> (bus_rdata == '0 && !tx_valid && !rx_ready));

    // R10
    pwr_irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_off) |-> (!irq_rx_done && !irq_tx_done && !irq_dr_empty));

    // R4
    rx_off_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_DATA && !ctrl[CB_RXON]) |-> (bus_rdata == '0));

    // R11
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr > OFS_DIVH) |-> (bus_rdata == '0));
endmodule

// File: tb/uart_regfront_tb_top.sv
module uart_regfront_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_off = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready, tx_valid;
    logic [7:0] tx_data;
    logic       irq_rx_done, irq_tx_done, irq_dr_empty;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    uart_regfront dut_i (
        .clk(clk), .rst(rst), .pwr_off(pwr_off),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .irq_rx_done(irq_rx_done), .irq_tx_done(irq_tx_done),
        .irq_dr_empty(irq_dr_empty)
    );

    // vector: {req, is_write, offset, data, expected read}
    localparam int NVEC = 25;
    localparam logic [23:0] VEC [0:NVEC-1] = '{
        {4'd1,  1'b0, 3'd1, 8'h00, 8'h20},  // R1 status
        {4'd1,  1'b0, 3'd2, 8'h00, 8'h00},  // R1 control B
        {4'd1,  1'b0, 3'd3, 8'h00, 8'h06},  // R1 control C
        {4'd1,  1'b0, 3'd4, 8'h00, 8'h00},  // R1 divisor low
        {4'd1,  1'b0, 3'd5, 8'h00, 8'h00},  // R1 divisor high
        {4'd9,  1'b1, 3'd4, 8'hAB, 8'h00},  // R9
        {4'd9,  1'b0, 3'd4, 8'h00, 8'hAB},
        {4'd9,  1'b1, 3'd5, 8'hFF, 8'h00},
        {4'd9,  1'b0, 3'd5, 8'h00, 8'h0F},  // R9 high byte 4 bits
        {4'd9,  1'b1, 3'd3, 8'h5A, 8'h00},
        {4'd9,  1'b0, 3'd3, 8'h00, 8'h5A},
        {4'd9,  1'b1, 3'd3, 8'h06, 8'h00},
        {4'd8,  1'b1, 3'd2, 8'hFF, 8'h00},  // R8
        {4'd8,  1'b0, 3'd2, 8'h00, 8'hFD},  // R8 bit 1 read-only
        {4'd8,  1'b1, 3'd2, 8'h00, 8'h00},
        {4'd8,  1'b0, 3'd2, 8'h00, 8'h00},
        {4'd7,  1'b1, 3'd1, 8'hFF, 8'h00},  // R7
        {4'd7,  1'b0, 3'd1, 8'h00, 8'h23},
        {4'd7,  1'b1, 3'd1, 8'h00, 8'h00},
        {4'd7,  1'b0, 3'd1, 8'h00, 8'h20},
        {4'd11, 1'b0, 3'd6, 8'h00, 8'h00},  // R11
        {4'd11, 1'b1, 3'd6, 8'h55, 8'h00},
        {4'd11, 1'b0, 3'd6, 8'h00, 8'h00},
        {4'd11, 1'b0, 3'd7, 8'h00, 8'h00},
        {4'd11, 1'b0, 3'd4, 8'h00, 8'hAB}
    };

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, "read", v, exp);
    endtask

    task automatic push(input logic [7:0] b);
        rx_data = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic dr_write_probe(input string tag, input logic [7:0] d, input logic exp_v);
        bus_addr = 3'd0; bus_wdata = d; bus_wr = 1'b1;
        #2;
        chk(tag, "tx_valid", {7'd0, tx_valid}, {7'd0, exp_v});
        if (exp_v) chk(tag, "tx_data", tx_data, d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic irq_chk(input string tag, input logic r, input logic t, input logic e);
        chk(tag, "irq rx/tx/empty", {5'd0, irq_rx_done, irq_tx_done, irq_dr_empty},
            {5'd0, r, t, e});
    endtask

    initial begin
        #4000000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        irq_chk("R1", 1'b0, 1'b0, 1'b0);
        chk("R1", "rx_ready", {7'd0, rx_ready}, 8'h00);
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][19]) begin
                wr(VEC[i][18:16], VEC[i][15:8]);
            end else begin
                rd(VEC[i][18:16], v);
                n_chk++;
                if (v !== VEC[i][7:0]) begin
                    n_err++;
                    $display("FAIL R%0d vector %0d: actual %02h expected %02h",
                             VEC[i][23:20], i, v, VEC[i][7:0]);
                end
            end
        end

        // R6 transmit path
        dr_write_probe("R6", 8'h3C, 1'b0);
        rd_chk("R6", 3'd1, 8'h20);
        wr(3'd2, 8'h08);
        dr_write_probe("R6", 8'h3C, 1'b1);
        rd_chk("R6", 3'd1, 8'h60);
        irq_chk("R6", 1'b0, 1'b0, 1'b0);
        wr(3'd2, 8'h68);
        irq_chk("R8", 1'b0, 1'b1, 1'b1);
        wr(3'd1, 8'h40);
        irq_chk("R7", 1'b0, 1'b0, 1'b1);
        rd_chk("R7", 3'd1, 8'h20);
        dr_write_probe("R6", 8'h77, 1'b1);
        irq_chk("R6", 1'b0, 1'b1, 1'b1);
        rd_chk("R6", 3'd1, 8'h20);
        wr(3'd2, 8'h00);
        irq_chk("R8", 1'b0, 1'b0, 1'b0);

        // R2 and R3 receive path
        wr(3'd2, 8'h90);
        #2 chk("R2", "rx_ready idle", {7'd0, rx_ready}, 8'h01);
        push(8'hE7);
        #2 chk("R2", "rx_ready full", {7'd0, rx_ready}, 8'h00);
        irq_chk("R2", 1'b1, 1'b0, 1'b0);
        rd_chk("R2", 3'd1, 8'hA0);
        rd_chk("R3", 3'd0, 8'hE7);
        irq_chk("R3", 1'b0, 1'b0, 1'b0);
        rd_chk("R3", 3'd1, 8'h20);
        rd_chk("R3", 3'd0, 8'h00);

        // R5 width masks
        wr(3'd3, 8'h00); push(8'hE7); rd_chk("R5", 3'd0, 8'h07);
        wr(3'd3, 8'h02); push(8'hE7); rd_chk("R5", 3'd0, 8'h27);
        wr(3'd3, 8'h04); push(8'hE7); rd_chk("R5", 3'd0, 8'h67);
        wr(3'd2, 8'h94); push(8'hE7); rd_chk("R5", 3'd0, 8'h67);
        wr(3'd3, 8'h00); push(8'hE7); rd_chk("R5", 3'd0, 8'h67);
        wr(3'd3, 8'h06); push(8'hE7); rd_chk("R5", 3'd0, 8'hE7);
        wr(3'd2, 8'h90);

        // R4 read with receiver off
        push(8'h5A);
        wr(3'd2, 8'h80);
        irq_chk("R8", 1'b1, 1'b0, 1'b0);
        rd_chk("R4", 3'd0, 8'h00);
        irq_chk("R4", 1'b1, 1'b0, 1'b0);
        rd_chk("R4", 3'd1, 8'hA0);
        wr(3'd2, 8'h90);
        #2 chk("R8", "flushed rx_ready", {7'd0, rx_ready}, 8'h01);
        rd_chk("R8", 3'd0, 8'h00);
        irq_chk("R3", 1'b0, 1'b0, 1'b0);

        // R12 read and arrival together, buffer full
        push(8'hC3);
        rx_data = 8'h11; rx_valid = 1'b1;
        bus_addr = 3'd0; bus_rd = 1'b1;
        #2;
        chk("R12", "rx_ready on read", {7'd0, rx_ready}, 8'h00);
        chk("R12", "old byte", bus_rdata, 8'hC3);
        @(negedge clk);
        bus_rd = 1'b0;
        #2 chk("R12", "rx_ready next", {7'd0, rx_ready}, 8'h01);
        @(negedge clk);
        rx_valid = 1'b0;
        rd_chk("R12", 3'd0, 8'h11);

        // R12 buffer empty
        rx_data = 8'h22; rx_valid = 1'b1;
        bus_addr = 3'd0; bus_rd = 1'b1;
        #2;
        chk("R12", "rx_ready empty read", {7'd0, rx_ready}, 8'h00);
        chk("R12", "empty read", bus_rdata, 8'h00);
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
        rx_valid = 1'b0;
        rd_chk("R12", 3'd0, 8'h22);

        // R10 power reduction
        wr(3'd4, 8'h55);
        wr(3'd2, 8'h98);
        pwr_off = 1'b1;
        #2 chk("R10", "rx_ready", {7'd0, rx_ready}, 8'h00);
        rd_chk("R10", 3'd4, 8'h00);
        dr_write_probe("R10", 8'h99, 1'b0);
        wr(3'd3, 8'h00);
        irq_chk("R10", 1'b0, 1'b0, 1'b0);
        pwr_off = 1'b0;
        rd_chk("R10", 3'd4, 8'h00);
        rd_chk("R10", 3'd2, 8'h00);
        rd_chk("R10", 3'd1, 8'h20);
        rd_chk("R10", 3'd3, 8'h06);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule